// File: doc/BRIEF.md
# Vector Length Configuration Unit

This block carries out one vector-length configuration request per strobe. The scalar pipeline presents a requested application vector length together with a proposed vector type word. The block pulls the element-width, grouping and division fields out of that word and decides whether the type is legal for this machine. It then either installs the new type and a granted length, or marks the configuration as illegal. The granted length is also returned so that it can be written to the scalar destination register.

The register width `VLEN`, the widest supported element `ELEN` and the scalar width `XLEN` are parameters. The maximum length for a type is computed on the fly: the register width times the grouping factor, divided by the element width. A small two-state controller sequences the work. `ST_IDLE` means no response is pending. `ST_RESP` means a request was committed on the previous edge and `rsp_done` is high. The transition `IDLE->RESP` and the self-loop `RESP->RESP` are taken on every edge with `req_valid` high. `RESP->IDLE` and `IDLE->IDLE` are taken when `req_valid` is low.

Top module: `vcfg_unit`

## Requirements
- R1: After reset, `vtype_o` has only bit XLEN-1 (the illegal flag) set, `vl_o`, `rsp_vl` and `vstart_o` are zero, and `rsp_done` is low.
- R2: The type word is decoded with the grouping code in bits [1:0] (factor 1, 2, 4 or 8 = 1 << code) and the width code in bits [4:2] (element width = 8 << code bits). The maximum length is VLEN * factor / width.
- R3: For a legal request whose length exceeds the maximum length, `vl_o` and `rsp_vl` both equal the maximum length.
- R4: For a legal request, `vtype_o` becomes the proposed word unchanged, and a request length at or below the maximum is granted as given.
- R5: A request whose decoded element width exceeds ELEN is illegal.
- R6: A request with bit XLEN-1 of the proposed word set is illegal.
- R7: A request with a nonzero division field (bits [6:5]) is illegal.
- R8: A request with any nonzero bit in the reserved range [XLEN-2:7] is illegal.
- R9: An illegal request leaves `vtype_o` with only bit XLEN-1 set, and sets `vl_o` and `rsp_vl` to zero.
- R10: Every request, legal or illegal, leaves `vstart_o` at zero.
- R11: A request is committed on the rising edge where `req_valid` is high. `rsp_done` is high in exactly the cycle that follows each such edge, and stays high across back-to-back requests.
- R12: On edges with `req_valid` low, `vtype_o`, `vl_o` and `rsp_vl` keep their values whatever `req_avl` and `req_vtype` carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, one request per high cycle |
| req_avl | input | XLEN | Requested application vector length |
| req_vtype | input | XLEN | Proposed vector type word |
| rsp_done | output | 1 | High for the cycle after a committed request |
| rsp_vl | output | XLEN | Granted length returned to the scalar destination |
| vtype_o | output | XLEN | Committed vector type |
| vl_o | output | XLEN | Committed vector length |
| vstart_o | output | XLEN | Start index, cleared by every request |

## Verification
The hardest cases to reach from the ports are the clamp boundary and the legality edges. These are a length exactly at the maximum and one above it for every width and grouping pair, and a width equal to ELEN against the next code up. A lone reserved bit at either end of its range, and the division field alone, must also each make a request illegal. A directed sweep walks all legal width and grouping pairs with lengths at maximum-1, maximum, maximum+1 and all-ones. It then flips each illegal cause in isolation, followed by a legal request so that recovery is seen. A seeded random phase mixes these causes and gaps. A behavioural reference in the bench recomputes every expected value with integer arithmetic and compares all outputs on each clock.

// File: rtl/vcfg_pkg.sv
package vcfg_pkg;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } vcfg_state_e;

    localparam int LMUL_LO = 0;
    localparam int LMUL_W  = 2;
    localparam int SEW_LO  = 2;
    localparam int SEW_W   = 3;
    localparam int EDIV_LO = 5;
    localparam int EDIV_W  = 2;
    localparam int RSV_LO  = 7;

    typedef struct packed {
        logic [SEW_W-1:0]  sew_code;
        logic [LMUL_W-1:0] lmul_code;
        logic [EDIV_W-1:0] ediv;
        logic              rsv_nz;
        logic              ill_in;
    } vtype_fields_t;

endpackage

// File: rtl/vcfg_field_decode.sv
module vcfg_field_decode
    import vcfg_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int ELEN = 32
) (
    input  logic [XLEN-1:0] vtype_word,
    output vtype_fields_t   fields,
    output logic            legal
);
    localparam int NUM_SEW = 1 << SEW_W;

    logic [NUM_SEW-1:0] sew_fits;

    generate
        for (genvar g = 0; g < NUM_SEW; g++) begin : g_sew_fit
            localparam int WIDTH_BITS = 8 << g;
            assign sew_fits[g] = (WIDTH_BITS <= ELEN) ? 1'b1 : 1'b0;
        end
    endgenerate

    always_comb begin
        fields.sew_code  = vtype_word[SEW_LO +: SEW_W];
        fields.lmul_code = vtype_word[LMUL_LO +: LMUL_W];
        fields.ediv      = vtype_word[EDIV_LO +: EDIV_W];
        fields.rsv_nz    = |vtype_word[XLEN-2:RSV_LO];
        fields.ill_in    = vtype_word[XLEN-1];
    end

    always_comb begin
        legal = sew_fits[fields.sew_code]
              & ~fields.ill_in
              & ~(|fields.ediv)
              & ~fields.rsv_nz;
    end

endmodule

// File: rtl/vcfg_vlmax.sv
module vcfg_vlmax
    import vcfg_pkg::*;
#(
    parameter int VLEN = 128,
    parameter int VLW  = 8
) (
    input  logic [SEW_W-1:0]  sew_code,
    input  logic [LMUL_W-1:0] lmul_code,
    output logic [VLW-1:0]    vlmax
);
    localparam int PW = $clog2(VLEN) + 4;

    logic [PW-1:0] group_bits;
    logic [PW-1:0] elems;
    logic [3:0]    shift_amt;

    always_comb begin
        group_bits = PW'(VLEN) << lmul_code;
        shift_amt  = {1'b0, sew_code} + 4'd3;
        elems      = group_bits >> shift_amt;
        vlmax      = elems[VLW-1:0];
    end

endmodule

// File: rtl/vcfg_clamp.sv
module vcfg_clamp #(
    parameter int XLEN = 32,
    parameter int VLW  = 8
) (
    input  logic [XLEN-1:0] avl,
    input  logic [VLW-1:0]  vlmax,
    output logic [VLW-1:0]  granted
);
    logic fits;

    always_comb begin
        fits    = (avl <= XLEN'(vlmax));
        granted = fits ? avl[VLW-1:0] : vlmax;
    end

endmodule

// File: rtl/vcfg_unit.sv
module vcfg_unit
    import vcfg_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int VLEN = 128,
    parameter int ELEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic [XLEN-1:0] req_avl,
    input  logic [XLEN-1:0] req_vtype,
    output logic            rsp_done,
    output logic [XLEN-1:0] rsp_vl,
    output logic [XLEN-1:0] vtype_o,
    output logic [XLEN-1:0] vl_o,
    output logic [XLEN-1:0] vstart_o
);
    localparam int VLW = $clog2(VLEN) + 1;
    localparam logic [XLEN-1:0] ILL_ONLY = {1'b1, {(XLEN-1){1'b0}}};

    vtype_fields_t  fields;
    logic           legal;
    logic [VLW-1:0] vlmax;
    logic [VLW-1:0] granted;
    vcfg_state_e    state_q;
    vcfg_state_e    state_d;

    vcfg_field_decode #(.XLEN(XLEN), .ELEN(ELEN)) u_decode (
        .vtype_word (req_vtype),
        .fields     (fields),
        .legal      (legal)
    );

    vcfg_vlmax #(.VLEN(VLEN), .VLW(VLW)) u_vlmax (
        .sew_code  (fields.sew_code),
        .lmul_code (fields.lmul_code),
        .vlmax     (vlmax)
    );

    vcfg_clamp #(.XLEN(XLEN), .VLW(VLW)) u_clamp (
        .avl     (req_avl),
        .vlmax   (vlmax),
        .granted (granted)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = req_valid ? ST_RESP : ST_IDLE;
            ST_RESP: state_d = req_valid ? ST_RESP : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vtype_o  <= ILL_ONLY;
            vl_o     <= '0;
            rsp_vl   <= '0;
            vstart_o <= '0;
        end else if (req_valid) begin
            vstart_o <= '0;
            if (legal) begin
                vtype_o <= req_vtype;
                vl_o    <= XLEN'(granted);
                rsp_vl  <= XLEN'(granted);
            end else begin
                vtype_o <= ILL_ONLY;
                vl_o    <= '0;
                rsp_vl  <= '0;
            end
        end
    end

    assign rsp_done = (state_q == ST_RESP);

    // R11
    done_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_done);

    // R11
    done_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_done);

    // R12
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> ($stable(vtype_o) && $stable(vl_o) && $stable(rsp_vl)));

    // R9
    illegal_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !legal) |=> (vl_o == '0 && rsp_vl == '0 && vtype_o == ILL_ONLY));

    // R3
    vl_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && legal) |=> (vl_o <= $past(req_avl) && vl_o <= XLEN'(VLEN)));

    // R4
    legal_type_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && legal) |=> (vtype_o == $past(req_vtype)));

    // R10
    vstart_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (vstart_o == '0));

endmodule

// File: tb/vcfg_unit_test.sv
`timescale 1ns/1ps
module vcfg_unit_test;
    localparam int XLEN = 32;
    localparam int VLEN = 128;
    localparam int ELEN = 32;
    localparam longint ILL = 64'h8000_0000;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            req_valid = 1'b0;
    logic [XLEN-1:0] req_avl = '0;
    logic [XLEN-1:0] req_vtype = '0;
    logic            rsp_done;
    logic [XLEN-1:0] rsp_vl;
    logic [XLEN-1:0] vtype_o;
    logic [XLEN-1:0] vl_o;
    logic [XLEN-1:0] vstart_o;

    int checks = 0;
    int fails = 0;
    int cycles = 0;

    longint exp_vtype = ILL;
    longint exp_vl = 0;
    longint exp_rvl = 0;
    bit     exp_done = 0;
    string  exp_tag = "R1";
    string  cur_tag = "R4";

    vcfg_unit #(.XLEN(XLEN), .VLEN(VLEN), .ELEN(ELEN)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_avl(req_avl),
        .req_vtype(req_vtype), .rsp_done(rsp_done), .rsp_vl(rsp_vl),
        .vtype_o(vtype_o), .vl_o(vl_o), .vstart_o(vstart_o)
    );

    always #5 clk = ~clk;

    function automatic longint ref_vlmax(longint vt);
        longint sew = 8 << ((vt >> 2) & 7);
        longint mul = 1 << (vt & 3);
        return (VLEN * mul) / sew;
    endfunction

    function automatic bit ref_legal(longint vt);
        longint sew = 8 << ((vt >> 2) & 7);
        if (sew > ELEN) return 0;
        if (((vt >> 31) & 1) != 0) return 0;
        if (((vt >> 5) & 3) != 0) return 0;
        if (((vt >> 7) & 64'hFF_FFFF) != 0) return 0;
        return 1;
    endfunction

    // Behavioural reference, updated on the commit edge
    always @(posedge clk) begin
        if (!rst_n) begin
            exp_vtype <= ILL; exp_vl <= 0; exp_rvl <= 0; exp_done <= 0; exp_tag <= "R1";
        end else begin
            exp_done <= req_valid;
            if (req_valid) begin
                longint vt;
                longint av;
                longint mx;
                vt = longint'(req_vtype);
                av = longint'(req_avl);
                mx = ref_vlmax(vt);
                exp_tag <= cur_tag;
                if (ref_legal(vt)) begin
                    exp_vtype <= vt;
                    exp_vl  <= (av <= mx) ? av : mx;
                    exp_rvl <= (av <= mx) ? av : mx;
                end else begin
                    exp_vtype <= ILL; exp_vl <= 0; exp_rvl <= 0;
                end
            end
        end
    end

    task automatic check(string tag, string what, longint act, longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Compare every cycle, away from the active edge
    always @(negedge clk) begin
        cycles++;
        if (rst_n) begin
            check(exp_tag, "vtype", longint'(vtype_o), exp_vtype);
            check(exp_tag, "vl", longint'(vl_o), exp_vl);
            check(exp_tag, "rsp_vl", longint'(rsp_vl), exp_rvl);
            check("R10", "vstart", longint'(vstart_o), 0);
            check(exp_done ? "R11" : "R12", "done", longint'(rsp_done), longint'(exp_done));
        end
    end

    task automatic summary;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    always @(negedge clk) begin
        if (cycles > 100000) begin
            checks++; fails++;
            $display("FAIL watchdog: actual=hung expected=finish");
            summary();
        end
    end

    task automatic req(string tag, longint avl, longint vt);
        cur_tag = tag;
        req_valid = 1'b1;
        req_avl = avl[XLEN-1:0];
        req_vtype = vt[XLEN-1:0];
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic idle(int n, bit scramble);
        for (int i = 0; i < n; i++) begin
            if (scramble) begin
                req_avl = $urandom;
                req_vtype = $urandom;
            end
            @(negedge clk);
        end
    endtask

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1", "reset vtype", longint'(vtype_o), ILL);
        check("R1", "reset vl", longint'(vl_o), 0);
        check("R1", "reset rsp_vl", longint'(rsp_vl), 0);
        check("R1", "reset vstart", longint'(vstart_o), 0);
        check("R1", "reset done", longint'(rsp_done), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2/R3/R4: every legal width and grouping pair around the boundary
        for (int s = 0; s < 3; s++) begin
            for (int m = 0; m < 4; m++) begin
                longint vt = (s << 2) | m;
                longint mx = ref_vlmax(vt);
                req("R2", mx, vt);
                req("R4", mx - 1, vt);
                req("R3", mx + 1, vt);
                req("R3", 64'hFFFF_FFFF, vt);
                idle(1, 1'b0);
            end
        end
        req("R4", 0, 0);

        // R5: width above ELEN, each code
        for (int s = 3; s < 8; s++) begin
            req("R5", 5, (s << 2) | 1);
            req("R4", 3, 1);
        end
        // R6: illegal flag set in the proposal
        req("R6", 4, ILL | 1);
        req("R4", 7, 2);
        // R7: division field
        for (int e = 1; e < 4; e++) begin
            req("R7", 4, (e << 5));
            req("R4", 2, 0);
        end
        // R8: reserved bits at each end and in the middle
        req("R8", 4, 1 << 7);
        req("R4", 9, 3);
        req("R8", 4, 1 << 30);
        req("R4", 9, 3);
        req("R8", 4, 1 << 18);
        // R9: illegal then idle keeps the zeroed state
        idle(2, 1'b1);
        req("R4", 16, 4);
        // R12: scrambled inputs with strobe low
        idle(5, 1'b1);

        // Mixed random phase
        for (int n = 0; n < 400; n++) begin
            int kind = $urandom % 8;
            longint vt = (($urandom % 4) << 2) | ($urandom % 4);
            longint mx = ref_vlmax(vt);
            longint av;
            string tg = "R4";
            case ($urandom % 4)
                0: av = $urandom % 8;
                1: av = mx + ($urandom % 3) - 1;
                2: av = $urandom;
                default: av = $urandom % 300;
            endcase
            if (kind == 1) begin vt = vt | ILL; tg = "R6"; end
            else if (kind == 2) begin vt = vt | ((1 + $urandom % 3) << 5); tg = "R7"; end
            else if (kind == 3) begin vt = vt | (longint'(1) << (7 + $urandom % 24)); tg = "R8"; end
            else if (((vt >> 2) & 7) == 3) tg = "R5";
            else if (av > mx) tg = "R3";
            req(tg, av, vt);
            if ($urandom % 3 == 0) idle(1 + $urandom % 2, 1'b1);
        end
        idle(3, 1'b0);
        summary();
    end

endmodule